// File: doc/BRIEF.md
# Multidrop JTAG Address Selection Controller

This block decides whether one bridge on a shared multidrop JTAG backplane is being addressed. It keeps its own 8-bit copy of the value shifted into the instruction register while the backplane TAP is in Shift-IR. On Update-IR it looks at that value. While the bridge is waiting for an address, the value is treated as an address. Once the bridge is selected, the value is treated as an instruction.

Three kinds of address are recognised, and all three use only the low six bits of the instruction register:

- **Direct address.** It must equal the six static slot pins. It selects the bridge alone and enables its backplane TDO driver.
- **Broadcast address.** It selects every bridge on the backplane at once.
- **Multicast group code.** It selects every bridge whose 2-bit group register holds that group index.

Under broadcast or multicast selection TDO stays disabled, so several bridges never drive the line against each other. A return-to-wait instruction releases the selection from any selected state and pulses a reset toward the local ports. An asynchronous TRST does the same and also clears the group register.

Top module: `mdrop_sel_ctrl`

## Requirements
- R1: After `trst_n` is released, the block waits for an address. `sel_direct`, `sel_bcast`, `sel_mcast`, `tdo_oe` and `lsp_rst` are all 0, and the group register is 0.
- R2: While `ir_shift` is high, each rising `tck` edge shifts `tdi` into the 8-bit capture register, least significant bit first. Shifting alone, without `ir_update`, changes no output.
- R3: In the wait state, an `ir_update` edge with IR[5:0] equal to `slot` selects the bridge directly when `slot` is below 0x3B. `sel_direct` and `tdo_oe` go high after that edge, whatever IR[7:6] hold.
- R4: In the wait state, an update with a code that is a direct address other than `slot` leaves the block waiting.
- R5: In the wait state, code 0x3B in IR[5:0] gives broadcast selection: `sel_bcast` is 1 and `tdo_oe` stays 0.
- R6: In the wait state, a code of 0x3C+g in IR[5:0] (g = 0 to 3) gives multicast selection only if g equals the group register. Then `sel_mcast` is 1 and `tdo_oe` stays 0; otherwise the block keeps waiting.
- R7: In direct selection, instruction 0b101001gg writes g into the group register, and the selection is kept.
- R8: In any selected state, instruction 0xC3 returns the block to the wait state. It raises `lsp_rst` for exactly one cycle after that update.
- R9: In a selected state, any other instruction leaves the selection and all outputs unchanged. An address code is not re-evaluated there.
- R10: A `slot` value of 0x3B to 0x3F never gives direct selection. A matching code is decoded as broadcast or multicast instead.
- R11: Driving `trst_n` low asynchronously forces the wait state, clears all outputs and returns the group register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Backplane serial data in |
| ir_shift | input | 1 | Backplane TAP is in Shift-IR |
| ir_update | input | 1 | Backplane TAP is in Update-IR |
| slot | input | 6 | Static slot address pins |
| sel_direct | output | 1 | Bridge is directly selected |
| sel_bcast | output | 1 | Bridge is selected by broadcast |
| sel_mcast | output | 1 | Bridge is selected by multicast |
| tdo_oe | output | 1 | Backplane TDO driver enable |
| lsp_rst | output | 1 | One-cycle reset pulse toward the local ports |

## Verification
Every selection result and every `lsp_rst` pulse is due in the cycle right after the `tck` edge on which `ir_update` is high. The bench therefore drives on falling edges and compares all outputs at the falling edge that follows the update edge. No output may move during the shift cycles before an update. An asynchronous reset is checked one nanosecond after `trst_n` falls, with no clock edge in between.

// File: rtl/mdrop_sel_ctrl.sv
module mdrop_sel_ctrl #(
  parameter int IR_W = 8,
  parameter int ADDR_W = 6,
  parameter int GRP_W = 2,
  parameter logic [5:0] BCAST_CODE = 6'h3B,
  parameter logic [5:0] MCAST_BASE = 6'h3C,
  parameter logic [7:0] OP_RETURN = 8'hC3,
  parameter logic [5:0] OP_GRP_HI = 6'b101001
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              ir_shift,
  input  logic              ir_update,
  input  logic [ADDR_W-1:0] slot,
  output logic              sel_direct,
  output logic              sel_bcast,
  output logic              sel_mcast,
  output logic              tdo_oe,
  output logic              lsp_rst
);

  typedef enum logic [1:0] {S_WAIT, S_DIRECT, S_BCAST, S_MCAST} st_t;

  st_t              st, st_nx;
  logic [IR_W-1:0]  ir_q;
  logic [GRP_W-1:0] grp_q;

  wire [ADDR_W-1:0] code     = ir_q[ADDR_W-1:0];
  wire [ADDR_W-1:0] mc_off   = code - MCAST_BASE;
  wire              hit_dir  = (code == slot) && (code < BCAST_CODE);
  wire              hit_bc   = (code == BCAST_CODE);
  wire              hit_mc   = (code >= MCAST_BASE) && (mc_off[GRP_W-1:0] == grp_q);
  wire              op_ret   = (ir_q == OP_RETURN);
  wire              op_grp   = (ir_q[IR_W-1:GRP_W] == OP_GRP_HI);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)       ir_q <= '0;
    else if (ir_shift) ir_q <= {tdi, ir_q[IR_W-1:1]};

  always_comb begin
    st_nx = st;
    if (ir_update) begin
      if (st == S_WAIT) begin
        if (hit_dir)     st_nx = S_DIRECT;
        else if (hit_bc) st_nx = S_BCAST;
        else if (hit_mc) st_nx = S_MCAST;
      end else if (op_ret) begin
        st_nx = S_WAIT;
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      st      <= S_WAIT;
      grp_q   <= '0;
      lsp_rst <= 1'b0;
    end else begin
      st      <= st_nx;
      lsp_rst <= ir_update && (st != S_WAIT) && op_ret;
      if (ir_update && st == S_DIRECT && op_grp)
        grp_q <= ir_q[GRP_W-1:0];
    end

  assign sel_direct = (st == S_DIRECT);
  assign sel_bcast  = (st == S_BCAST);
  assign sel_mcast  = (st == S_MCAST);
  assign tdo_oe     = sel_direct;

  assert_one_sel_R5: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({sel_direct, sel_bcast, sel_mcast}));

  assert_oe_direct_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_update && st == S_WAIT && ir_q[ADDR_W-1:0] == slot && slot < BCAST_CODE) |=> tdo_oe);

  assert_hold_no_update_R2: assert property (@(posedge tck) disable iff (!trst_n)
    !ir_update |=> ($stable(st) && $stable(grp_q) && !lsp_rst));

  assert_ret_pulse_R8: assert property (@(posedge tck) disable iff (!trst_n)
    lsp_rst |-> (!sel_direct && !sel_bcast && !sel_mcast && $past(ir_update)));

  assert_grp_only_direct_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_DIRECT) |=> $stable(grp_q));

  assert_bad_slot_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (slot >= BCAST_CODE && st == S_WAIT) |=> !sel_direct);

endmodule

// File: tb/test_mdrop_sel_ctrl.sv
module test_mdrop_sel_ctrl;
  logic tck = 0, trst_n = 0, tdi = 0, ir_shift = 0, ir_update = 0;
  logic [5:0] slot = 6'd5;
  logic sel_direct, sel_bcast, sel_mcast, tdo_oe, lsp_rst;

  mdrop_sel_ctrl i_mdrop_sel_ctrl (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .ir_shift(ir_shift), .ir_update(ir_update),
    .slot(slot), .sel_direct(sel_direct), .sel_bcast(sel_bcast), .sel_mcast(sel_mcast),
    .tdo_oe(tdo_oe), .lsp_rst(lsp_rst));

  always #4 tck = ~tck;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_st = 0;
  int m_grp = 0;
  bit m_rst = 0;
  string m_tag;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, int'(sel_direct), int'(m_st == 1), "sel_direct");
    chk(req, int'(sel_bcast),  int'(m_st == 2), "sel_bcast");
    chk(req, int'(sel_mcast),  int'(m_st == 3), "sel_mcast");
    chk(req, int'(tdo_oe),     int'(m_st == 1), "tdo_oe");
    chk(req, int'(lsp_rst),    int'(m_rst),     "lsp_rst");
  endtask

  function automatic int mc_idx(logic [5:0] c);
    return int'(c) - 60;
  endfunction

  task automatic model(logic [7:0] v);
    logic [5:0] c = v[5:0];
    m_rst = 0;
    if (m_st == 0) begin
      if (c == slot && c < 6'h3B) begin m_st = 1; m_tag = "R3"; end
      else if (c == 6'h3B) begin m_st = 2; m_tag = "R5"; end
      else if (c >= 6'h3C && mc_idx(c) == m_grp) begin m_st = 3; m_tag = "R6"; end
      else m_tag = (slot >= 6'h3B && c == slot) ? "R10" : (c >= 6'h3C ? "R6" : "R4");
    end else if (v == 8'hC3) begin
      m_st = 0; m_rst = 1; m_tag = "R8";
    end else if (m_st == 1 && v[7:2] == 6'b101001) begin
      m_grp = int'(v[1:0]); m_tag = "R7";
    end else m_tag = "R9";
  endtask

  task automatic shift_only(logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge tck); ir_shift = 1; tdi = v[i];
    end
    @(negedge tck); ir_shift = 0;
  endtask

  task automatic load(logic [7:0] v);
    shift_only(v);
    ir_update = 1;
    @(negedge tck); ir_update = 0;
    model(v);
    chk_all(m_tag);
  endtask

  task automatic do_reset(string req);
    @(negedge tck); trst_n = 0;
    #1;
    m_st = 0; m_grp = 0; m_rst = 0;
    chk_all(req);
    @(negedge tck); trst_n = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge tck);
    trst_n = 1;
    @(negedge tck);
    chk_all("R1");
    // R2: shifting a matching address without update does nothing
    shift_only(8'h05);
    chk_all("R2");
    load(8'h12);               // R4 mismatch
    load(8'hC5);               // R3 upper bits ignored
    load(8'hA6);               // R7 group 2
    load(8'h77);               // R9 other instruction
    load(8'hC3);               // R8 return
    @(negedge tck); m_rst = 0; chk_all("R8");
    load(8'h3E);               // R6 group 2 member
    load(8'hC3);
    load(8'h3C);               // R6 not a member
    load(8'h3B);               // R5 broadcast
    load(8'h05);               // R9 address ignored while selected
    load(8'hA4);               // R9 no group write in broadcast
    load(8'hC3);
    slot = 6'h3D;
    load(8'h3D);               // R10 slot invalid, group 1 not member
    slot = 6'h3B;
    load(8'h3B);               // R10 decoded as broadcast
    load(8'hC3);
    slot = 6'd5;
    load(8'h05);
    do_reset("R11");
    load(8'h3C);               // R11 group cleared to 0 -> member
    do_reset("R11");
    load(8'h3E);               // R11 group 2 no longer held
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] v;
      if (r < 4) begin do_reset("R11"); continue; end
      if (r < 8) slot = 6'($urandom_range(0, 63));
      r = $urandom_range(0, 99);
      if (r < 30) v = 8'hC3;
      else if (r < 50) v = {2'($urandom_range(0, 3)), slot};
      else if (r < 65) v = {6'b101001, 2'($urandom_range(0, 3))};
      else if (r < 80) v = {2'($urandom_range(0, 3)), 6'($urandom_range(59, 63))};
      else v = 8'($urandom_range(0, 255));
      load(v);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule